// File: doc/BRIEF.md
# Fetch Thread Selector

This block decides, once per cycle, which hardware thread a multithreaded fetch stage serves next. Each thread presents a three-bit status code and an active bit. A mode input picks between a fixed mode, which always serves thread 0, and a rotating mode. In the rotating mode the block keeps an ordered priority list of thread indices. It grants the first eligible thread in that list and then moves only the granted thread to the tail.

The grant is combinational from the current inputs and the stored list. The list changes only at a clock edge that follows a rotating-mode grant. Threads that were skipped because they were ineligible keep their places, so a thread that has just recovered from a stall is served ahead of threads that were granted recently. A build with one configured thread omits the list. It grants thread 0 when that thread is active and eligible. An error output flags fixed mode when more than one thread is configured.

The decision kind is held in an enumerated value: PICK_NONE (no grant), PICK_FIXED (fixed mode, thread 0) and PICK_LIST (rotating-mode grant from the list). On every strobe exactly one of these is taken. The list register moves from its current order to the rotated order only on a PICK_LIST cycle. Every other decision holds the list.

Top module: `fsel_thread_pick`

## Requirements
- R1: A thread is eligible only when its active bit is set and its status code is 0 (running), 1 (idle) or 4 (fill done). Codes 2, 3, 5, 6 and 7 are never granted. The status of thread t sits in bits [3t+2:3t] of `thr_state`.
- R2: In rotating mode (`sel_mode`=1) with the strobe high, the grant is the eligible thread that stands nearest the head of the priority list.
- R3: After a rotating-mode grant, the granted thread moves to the tail at the next clock edge. The other threads keep their relative order.
- R4: In rotating mode, if no listed thread is eligible, `grant_valid` is low and the list is unchanged.
- R5: In fixed mode (`sel_mode`=0) with the strobe high, `grant_valid` is high and `grant_tid` is 0 whatever the status and active inputs are, and the list does not move.
- R6: After reset the priority list holds the threads in ascending index order, with thread 0 at the head.
- R7: With one configured thread in rotating mode, thread 0 is granted exactly when it is active and eligible.
- R8: While `sel_strobe` is low, `grant_valid` is low and the list does not move.
- R9: `cfg_err` is high exactly when fixed mode is selected and more than one thread is configured.
- R10: The grant reflects the inputs in the same cycle. The list update takes effect from the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_state | input | 3*NUM_THREADS | Per-thread status codes, thread t in bits [3t+2:3t] |
| thr_active | input | NUM_THREADS | Per-thread active mask |
| sel_mode | input | 1 | 0 = fixed thread 0, 1 = rotating list |
| sel_strobe | input | 1 | Request a selection this cycle |
| grant_valid | output | 1 | A thread is granted this cycle |
| grant_tid | output | TID_W | Index of the granted thread |
| cfg_err | output | 1 | Fixed mode selected with more than one thread configured |

## Verification
The assertions assume that the mode, strobe, active mask and status codes are steady across each rising edge. They also assume that any 3-bit status value may appear, including codes that no thread normally reports. The stimulus changes inputs only at falling edges and samples outputs shortly afterwards. It sweeps every status combination of a three-thread build under changing active masks, with strobe-low cycles mixed in. Fixed-mode cycles are placed between rotating-mode cycles, so a list disturbed by a fixed-mode cycle shows up in the rotating grants that follow.

// File: rtl/fsel_pkg.sv
package fsel_pkg;

    localparam int STATE_W = 3;

    typedef enum logic [STATE_W-1:0] {
        TS_RUN       = 3'd0,
        TS_IDLE      = 3'd1,
        TS_SQUASH    = 3'd2,
        TS_STALL     = 3'd3,
        TS_FILL_DONE = 3'd4,
        TS_WAIT_FILL = 3'd5,
        TS_WAIT_SLOT = 3'd6,
        TS_OFF       = 3'd7
    } thr_state_e;

    typedef enum logic {
        MODE_FIXED  = 1'b0,
        MODE_ROTATE = 1'b1
    } sel_mode_e;

    typedef enum logic [1:0] {
        PICK_NONE  = 2'd0,
        PICK_FIXED = 2'd1,
        PICK_LIST  = 2'd2
    } pick_kind_e;

    function automatic logic state_servable(input logic [STATE_W-1:0] code);
        logic ok;
        unique case (thr_state_e'(code))
            TS_RUN, TS_IDLE, TS_FILL_DONE: ok = 1'b1;
            default:                       ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/fsel_elig.sv
module fsel_elig
    import fsel_pkg::*;
#(
    parameter int NUM_THREADS = 4
) (
    input  logic [NUM_THREADS*STATE_W-1:0] state_vec,
    input  logic [NUM_THREADS-1:0]         active,
    output logic [NUM_THREADS-1:0]         ready
);

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
        assign ready[t] = active[t] && state_servable(state_vec[t*STATE_W +: STATE_W]);
    end

endmodule

// File: rtl/fsel_scan.sv
module fsel_scan #(
    parameter int NUM_THREADS = 4,
    parameter int TID_W       = 2
) (
    input  logic [NUM_THREADS*TID_W-1:0] order_flat,
    input  logic [NUM_THREADS-1:0]       ready,
    output logic                         found,
    output logic [TID_W-1:0]             pos,
    output logic [TID_W-1:0]             tid
);

    localparam int SLOTS = 1 << TID_W;

    logic [SLOTS-1:0] ready_ext;

    always_comb begin
        ready_ext = '0;
        ready_ext[NUM_THREADS-1:0] = ready;
    end

    always_comb begin
        logic [TID_W-1:0] cand;
        found = 1'b0;
        pos   = '0;
        tid   = '0;
        for (int p = 0; p < NUM_THREADS; p++) begin
            cand = order_flat[p*TID_W +: TID_W];
            if (!found && ready_ext[cand]) begin
                found = 1'b1;
                pos   = TID_W'(p);
                tid   = cand;
            end
        end
    end

endmodule

// File: rtl/fsel_plist.sv
module fsel_plist #(
    parameter int NUM_THREADS = 4,
    parameter int TID_W       = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         rotate,
    input  logic [TID_W-1:0]             pos,
    input  logic [TID_W-1:0]             tid,
    output logic [NUM_THREADS*TID_W-1:0] order_flat
);

    logic [TID_W-1:0] order_q [NUM_THREADS];
    logic [TID_W-1:0] order_d [NUM_THREADS];

    always_comb begin
        for (int i = 0; i < NUM_THREADS; i++) begin
            order_d[i] = order_q[i];
        end
        if (rotate) begin
            for (int i = 0; i < NUM_THREADS - 1; i++) begin
                if (i >= int'(pos)) begin
                    order_d[i] = order_q[i+1];
                end
            end
            order_d[NUM_THREADS-1] = tid;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_THREADS; i++) begin
                order_q[i] <= TID_W'(i);
            end
        end else begin
            for (int i = 0; i < NUM_THREADS; i++) begin
                order_q[i] <= order_d[i];
            end
        end
    end

    for (genvar i = 0; i < NUM_THREADS; i++) begin : g_flat
        assign order_flat[i*TID_W +: TID_W] = order_q[i];
    end

endmodule

// File: rtl/fsel_thread_pick.sv
module fsel_thread_pick
    import fsel_pkg::*;
#(
    parameter int NUM_THREADS = 4,
    localparam int TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_THREADS*STATE_W-1:0] thr_state,
    input  logic [NUM_THREADS-1:0]         thr_active,
    input  logic                           sel_mode,
    input  logic                           sel_strobe,
    output logic                           grant_valid,
    output logic [TID_W-1:0]               grant_tid,
    output logic                           cfg_err
);

    logic [NUM_THREADS-1:0]       ready;
    logic [NUM_THREADS*TID_W-1:0] order_flat;
    logic                         list_found;
    logic [TID_W-1:0]             list_pos;
    logic [TID_W-1:0]             list_tid;
    logic                         list_rotate;
    pick_kind_e                   pick_kind;

    fsel_elig #(.NUM_THREADS(NUM_THREADS)) u_elig (
        .state_vec (thr_state),
        .active    (thr_active),
        .ready     (ready)
    );

    if (NUM_THREADS > 1) begin : g_multi
        fsel_scan #(.NUM_THREADS(NUM_THREADS), .TID_W(TID_W)) u_scan (
            .order_flat (order_flat),
            .ready      (ready),
            .found      (list_found),
            .pos        (list_pos),
            .tid        (list_tid)
        );

        fsel_plist #(.NUM_THREADS(NUM_THREADS), .TID_W(TID_W)) u_plist (
            .clk        (clk),
            .rst_n      (rst_n),
            .rotate     (list_rotate),
            .pos        (list_pos),
            .tid        (list_tid),
            .order_flat (order_flat)
        );
    end else begin : g_single
        assign order_flat = '0;
        assign list_found = ready[0];
        assign list_pos   = '0;
        assign list_tid   = '0;
    end

    always_comb begin
        if (!sel_strobe) begin
            pick_kind = PICK_NONE;
        end else if (sel_mode_e'(sel_mode) == MODE_FIXED) begin
            pick_kind = PICK_FIXED;
        end else if (list_found) begin
            pick_kind = PICK_LIST;
        end else begin
            pick_kind = PICK_NONE;
        end
    end

    always_comb begin
        grant_valid = 1'b0;
        grant_tid   = '0;
        list_rotate = 1'b0;
        unique case (pick_kind)
            PICK_FIXED: begin
                grant_valid = 1'b1;
                grant_tid   = '0;
            end
            PICK_LIST: begin
                grant_valid = 1'b1;
                grant_tid   = list_tid;
                list_rotate = (NUM_THREADS > 1);
            end
            default: begin
                grant_valid = 1'b0;
                grant_tid   = '0;
            end
        endcase
    end

    assign cfg_err = (NUM_THREADS > 1) && (sel_mode_e'(sel_mode) == MODE_FIXED);

endmodule

// File: rtl/fsel_thread_pick_chk.sv
module fsel_thread_pick_chk
    import fsel_pkg::*;
#(
    parameter int NUM_THREADS = 4,
    parameter int TID_W       = 2
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic [NUM_THREADS*STATE_W-1:0] thr_state,
    input logic [NUM_THREADS-1:0]         thr_active,
    input logic                           sel_mode,
    input logic                           sel_strobe,
    input logic                           grant_valid,
    input logic [TID_W-1:0]               grant_tid,
    input logic                           cfg_err,
    input logic [NUM_THREADS*TID_W-1:0]   order_flat
);

    localparam int SLOTS = 1 << TID_W;

    logic [SLOTS-1:0] act_ext;
    logic [SLOTS-1:0] srv_ext;
    logic             any_srv;
    logic             perm_ok;

    always_comb begin
        act_ext = '0;
        srv_ext = '0;
        for (int t = 0; t < NUM_THREADS; t++) begin
            act_ext[t] = thr_active[t];
            srv_ext[t] = state_servable(thr_state[t*STATE_W +: STATE_W]);
        end
        any_srv = |(act_ext & srv_ext);
    end

    always_comb begin
        int hits;
        perm_ok = 1'b1;
        for (int t = 0; t < NUM_THREADS; t++) begin
            hits = 0;
            for (int p = 0; p < NUM_THREADS; p++) begin
                if (int'(order_flat[p*TID_W +: TID_W]) == t) hits++;
            end
            if (hits != 1) perm_ok = 1'b0;
        end
    end

    AST_ROTATE_GRANT_SERVABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && sel_mode) |-> (act_ext[grant_tid] && srv_ext[grant_tid])); // R1

    AST_ROTATE_NONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_strobe && sel_mode && !any_srv) |-> !grant_valid); // R4

    AST_FIXED_THREAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_strobe && !sel_mode) |-> (grant_valid && grant_tid == '0)); // R5

    AST_STROBE_LOW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_strobe |-> !grant_valid); // R8

    AST_LIST_PERMUTATION: assert property (@(posedge clk) disable iff (!rst_n)
        perm_ok); // R6

    AST_GRANT_TO_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && sel_mode && NUM_THREADS > 1)
        |=> (order_flat[(NUM_THREADS-1)*TID_W +: TID_W] == $past(grant_tid))); // R3

    AST_LIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant_valid && sel_mode) |=> $stable(order_flat)); // R8

    AST_ERR_ONLY_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !sel_mode); // R9

endmodule

bind fsel_thread_pick fsel_thread_pick_chk #(
    .NUM_THREADS(NUM_THREADS),
    .TID_W(TID_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .thr_state   (thr_state),
    .thr_active  (thr_active),
    .sel_mode    (sel_mode),
    .sel_strobe  (sel_strobe),
    .grant_valid (grant_valid),
    .grant_tid   (grant_tid),
    .cfg_err     (cfg_err),
    .order_flat  (order_flat)
);

// File: tb/fsel_thread_pick_tb.sv
`timescale 1ns/1ps
module fsel_thread_pick_tb;

    localparam int N = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [8:0] st;
    logic [2:0] act;
    logic       mode;
    logic       strobe;
    logic       gv;
    logic [1:0] gt;
    logic       err;

    logic [2:0] st1;
    logic       act1;
    logic       mode1;
    logic       strobe1;
    logic       gv1;
    logic [0:0] gt1;
    logic       err1;

    int checks = 0;
    int fails  = 0;
    int ml [N];
    bit done = 0;

    always #5 clk = ~clk;

    fsel_thread_pick #(.NUM_THREADS(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .thr_state(st), .thr_active(act),
        .sel_mode(mode), .sel_strobe(strobe),
        .grant_valid(gv), .grant_tid(gt), .cfg_err(err)
    );

    fsel_thread_pick #(.NUM_THREADS(1)) u_dut_one (
        .clk(clk), .rst_n(rst_n), .thr_state(st1), .thr_active(act1),
        .sel_mode(mode1), .sel_strobe(strobe1),
        .grant_valid(gv1), .grant_tid(gt1), .cfg_err(err1)
    );

    function automatic bit servable(input logic [2:0] c);
        return (c == 3'd0) || (c == 3'd1) || (c == 3'd4);
    endfunction

    task automatic chk(input string req, input int actual, input int expected);
        checks++;
        if (actual !== expected) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    // One rotating-mode step on the three-thread instance, model updated after the edge.
    task automatic rot_step(input logic [8:0] s, input logic [2:0] a, input logic stb);
        int  epos;
        int  etid;
        bit  efound;
        @(negedge clk);
        st = s; act = a; mode = 1'b1; strobe = stb;
        efound = 0; epos = 0; etid = 0;
        for (int p = 0; p < N; p++) begin
            if (!efound && a[ml[p]] && servable(s[ml[p]*3 +: 3])) begin
                efound = 1; epos = p; etid = ml[p];
            end
        end
        #2;
        if (!stb) begin
            chk("R8 strobe low valid", int'(gv), 0);
        end else if (!efound) begin
            chk("R4 none eligible valid", int'(gv), 0);
        end else begin
            chk("R2 R1 grant valid", int'(gv), 1);
            chk("R2 R3 grant tid", int'(gt), etid);
        end
        chk("R9 err in rotate", int'(err), 0);
        @(posedge clk);
        if (stb && efound) begin
            for (int p = 0; p < N - 1; p++) begin
                if (p >= epos) ml[p] = ml[p+1];
            end
            ml[N-1] = etid;
        end
    endtask

    initial begin
        #100000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        st = '0; act = '0; mode = 1'b1; strobe = 1'b0;
        st1 = '0; act1 = 1'b0; mode1 = 1'b1; strobe1 = 1'b0;
        for (int i = 0; i < N; i++) ml[i] = i;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R6: reset order 0,1,2 shows as 0,1,2,0 grants with all eligible
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            st = '0; act = 3'b111; mode = 1'b1; strobe = 1'b1;
            #2;
            chk("R6 reset order grant", int'(gt), k % N);
            chk("R10 same-cycle valid", int'(gv), 1);
            @(posedge clk);
            for (int p = 0; p < N - 1; p++) ml[p] = ml[p+1];
            ml[N-1] = k % N;
        end

        // Sweep of every status combination under varied masks
        for (int s = 0; s < 512; s++) begin
            rot_step(9'(s), 3'(s * 5 + 3), (s % 5) != 4);
            if (s % 37 == 0) begin
                // R5: fixed mode grants 0 and must not move the list
                @(negedge clk);
                st = 9'(s); act = 3'(s); mode = 1'b0; strobe = 1'b1;
                #2;
                chk("R5 fixed valid", int'(gv), 1);
                chk("R5 fixed tid", int'(gt), 0);
                chk("R9 err fixed multi", int'(err), 1);
                @(posedge clk);
            end
        end

        // Single-thread build, R7
        for (int s = 0; s < 32; s++) begin
            @(negedge clk);
            st1 = 3'(s); act1 = s[3]; mode1 = s[4]; strobe1 = 1'b1;
            #2;
            if (mode1) begin
                chk("R7 one-thread valid", int'(gv1), int'(act1 && servable(st1)));
            end else begin
                chk("R7 R5 one-thread fixed", int'(gv1), 1);
            end
            chk("R7 one-thread tid", int'(gt1), 0);
            chk("R9 one-thread err", int'(err1), 0);
            @(posedge clk);
        end
        @(negedge clk);
        strobe1 = 1'b0;
        #2;
        chk("R8 one-thread strobe low", int'(gv1), 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule